// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns bus addresses from a console's CPU and picture processor into physical addresses for cartridge program ROM, character memory and battery-backed work RAM. Four 5-bit configuration values (a control value, two character-bank values and a program-bank value) arrive as inputs. Whatever loads them lies outside the block. All translated addresses are produced combinationally from these values and the live bus addresses, so a new configuration value takes effect on the very next access.

The control value picks one of three program layouts, a 4 KB or 8 KB character layout, and a two-bit screen mirroring code. Bit 4 of the first character-bank value also serves as the top program bank bit, which selects one half of a 512 KB program space. It can also select the 8 KB work-RAM bank on boards with 16 KB of work RAM. Bit 4 of the program-bank value is an active-low work-RAM enable. While work RAM is disabled, reads of its window are flagged as open bus. The block then presents the last value that was actually driven on the CPU data bus, which is its only piece of state.

Top module: `cart_bank_xlat`

## Requirements
- R1: With control bits 3..2 = 11, CPU addresses with bit 14 = 0 map to 16 KB bank {half, prg[3:0]}, and addresses with bit 14 = 1 map to bank {half, 1111}.
- R2: With control bits 3..2 = 10, CPU addresses with bit 14 = 0 map to bank {half, 0000}, and addresses with bit 14 = 1 map to bank {half, prg[3:0]}.
- R3: With control bits 3..2 = 00 or 01, a 32 KB window maps to bank {half, prg[3:1], cpu_addr[14]}, so prg bit 0 is ignored.
- R4: The half bit in R1 to R3 is chr0 bit 4, and it adds 16 to every program bank number.
- R5: With control bit 4 = 1, picture addresses with bit 12 = 0 use 4 KB bank chr0, and those with bit 12 = 1 use 4 KB bank chr1.
- R6: With control bit 4 = 0, one 8 KB bank chr0>>1 covers 0x0000 to 0x1FFF: the 4 KB bank is {chr0[4:1], ppu_addr[12]}, and chr1 is ignored.
- R7: mirror equals control bits 1..0: 0 is one-screen lower, 1 is one-screen upper, 2 is vertical, 3 is horizontal.
- R8: wram_ce is 1 exactly for a valid access to 0x6000 to 0x7FFF while prg bit 4 is 0. wram_we is wram_ce together with a write.
- R9: A valid read of 0x6000 to 0x7FFF while prg bit 4 is 1 raises open_bus. A write there raises neither wram_ce nor wram_we. open_bus_data holds the cpu_bus value of the most recent valid access that was not open bus, and it is 0 after reset.
- R10: With WRAM_16K = 1, the work-RAM bank bit (wram_addr bit 13) is chr0[4] in 4 KB character mode and chr0[3] in 8 KB mode. With WRAM_16K = 0 it is 0.
- R11: Program and character bank numbers are reduced modulo PRG_BANKS and CHR_BANKS (powers of two), so smaller boards wrap.
- R12: A change of any configuration input changes the translated outputs in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the last-bus-value register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 5 | Control value: mirroring [1:0], program layout [3:2], character layout [4] |
| chr0 | input | 5 | First character bank; bit 4 also selects the program half and work-RAM bank |
| chr1 | input | 5 | Second character bank (4 KB mode) |
| prg | input | 5 | Program bank [3:0]; bit 4 disables work RAM |
| cpu_addr | input | 16 | CPU bus address |
| cpu_valid | input | 1 | CPU access in this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_bus | input | 8 | Value driven on the CPU data bus this cycle |
| ppu_addr | input | 13 | Picture processor pattern address |
| prg_addr | output | $clog2(PRG_BANKS)+14 | Physical program ROM address |
| chr_addr | output | $clog2(CHR_BANKS)+12 | Physical character memory address |
| wram_addr | output | 14 | Physical work-RAM address |
| wram_ce | output | 1 | Work-RAM chip enable |
| wram_we | output | 1 | Work-RAM write enable |
| open_bus | output | 1 | Read of disabled work RAM |
| open_bus_data | output | 8 | Last valid bus value, returned on open bus |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The hardest situation to reach is an open-bus read whose expected value comes from an access several cycles earlier. Between the two there may be more open-bus reads, which must not disturb the held value. The stimulus reaches this by biasing random addresses toward the work-RAM window and randomly toggling the enable bit. Directed runs of back-to-back disabled reads follow a known write. A second instance with small memory sizes receives the same stimulus and exposes wrapping of high bank numbers.

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 32,
  parameter bit WRAM_16K  = 1'b1,
  localparam int PB_W   = $clog2(PRG_BANKS),
  localparam int CB_W   = $clog2(CHR_BANKS),
  localparam int PRG_AW = PB_W + 14,
  localparam int CHR_AW = CB_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        ctrl,
  input  logic [4:0]        chr0,
  input  logic [4:0]        chr1,
  input  logic [4:0]        prg,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_bus,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [13:0]       wram_addr,
  output logic              wram_ce,
  output logic              wram_we,
  output logic              open_bus,
  output logic [7:0]        open_bus_data,
  output logic [1:0]        mirror
);

  logic [4:0] prg_bank;
  logic [4:0] chr_bank;
  logic       in_window;
  logic       wram_bank;
  logic [7:0] last_bus;

  always_comb begin
    case (ctrl[3:2])
      2'b11:   prg_bank = cpu_addr[14] ? {chr0[4], 4'hF} : {chr0[4], prg[3:0]};
      2'b10:   prg_bank = cpu_addr[14] ? {chr0[4], prg[3:0]} : {chr0[4], 4'h0};
      default: prg_bank = {chr0[4], prg[3:1], cpu_addr[14]};
    endcase
  end

  assign chr_bank = ctrl[4] ? (ppu_addr[12] ? chr1 : chr0)
                            : {chr0[4:1], ppu_addr[12]};

  assign prg_addr = {prg_bank[PB_W-1:0], cpu_addr[13:0]};
  assign chr_addr = {chr_bank[CB_W-1:0], ppu_addr[11:0]};

  assign in_window = cpu_valid && (cpu_addr[15:13] == 3'b011);
  assign wram_ce   = in_window && !prg[4];
  assign wram_we   = wram_ce && cpu_we;
  assign open_bus  = in_window && prg[4] && !cpu_we;
  assign wram_bank = WRAM_16K ? (ctrl[4] ? chr0[4] : chr0[3]) : 1'b0;
  assign wram_addr = {wram_bank, cpu_addr[12:0]};
  assign mirror    = ctrl[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      last_bus <= 8'h00;
    else if (cpu_valid && !open_bus) last_bus <= cpu_bus;
  end
  assign open_bus_data = last_bus;

  assert_wram_ce_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wram_ce |-> (!prg[4] && cpu_addr[15:13] == 3'b011));

  assert_ce_open_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wram_ce, open_bus}));

  assert_open_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus |=> $stable(open_bus_data));

  assert_bus_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !open_bus) |=> (open_bus_data == $past(cpu_bus)));

  assert_chr8k_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[4] |-> (chr_addr[12] == ppu_addr[12]));

  assert_prg32k_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] |-> (prg_addr[14] == cpu_addr[14]));

  assert_no_wram_write_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prg[4] && cpu_valid && cpu_we) |-> !wram_we);

endmodule

// File: tb/cart_bank_xlat_bench.sv
module cart_bank_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ctrl = '0, chr0 = '0, chr1 = '0, prg = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_bus = '0;
  logic [12:0] ppu_addr = '0;

  logic [18:0] prg_addr;  logic [16:0] chr_addr;  logic [13:0] wram_addr;
  logic        wram_ce, wram_we, open_bus;  logic [7:0] open_bus_data;  logic [1:0] mirror;
  logic [16:0] prg_addr_s; logic [14:0] chr_addr_s; logic [13:0] wram_addr_s;
  logic        wram_ce_s, wram_we_s, open_bus_s; logic [7:0] obd_s; logic [1:0] mirror_s;

  int checks = 0, errors = 0;
  logic [7:0] exp_last = 8'h00;
  logic prev_cap = 1'b0; logic [7:0] prev_bus = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  cart_bank_xlat u_cart_bank_xlat (
    .clk, .rst_n, .ctrl, .chr0, .chr1, .prg, .cpu_addr, .cpu_valid, .cpu_we, .cpu_bus,
    .ppu_addr, .prg_addr, .chr_addr, .wram_addr, .wram_ce, .wram_we, .open_bus,
    .open_bus_data, .mirror);

  cart_bank_xlat #(.PRG_BANKS(8), .CHR_BANKS(8), .WRAM_16K(1'b0)) u_small (
    .clk, .rst_n, .ctrl, .chr0, .chr1, .prg, .cpu_addr, .cpu_valid, .cpu_we, .cpu_bus,
    .ppu_addr, .prg_addr(prg_addr_s), .chr_addr(chr_addr_s), .wram_addr(wram_addr_s),
    .wram_ce(wram_ce_s), .wram_we(wram_we_s), .open_bus(open_bus_s),
    .open_bus_data(obd_s), .mirror(mirror_s));

  function automatic int exp_prg_bank();
    int half = chr0[4] ? 16 : 0;
    case (ctrl[3:2])
      2'b11:   return half + (cpu_addr[14] ? 15 : int'(prg[3:0]));
      2'b10:   return half + (cpu_addr[14] ? int'(prg[3:0]) : 0);
      default: return half + int'(prg[3:0] & 4'hE) + int'(cpu_addr[14]);
    endcase
  endfunction

  function automatic int exp_chr_bank();
    if (ctrl[4]) return ppu_addr[12] ? int'(chr1) : int'(chr0);
    return (int'(chr0) / 2) * 2 + int'(ppu_addr[12]);
  endfunction

  function automatic bit exp_open();
    return cpu_valid && !cpu_we && cpu_addr[15:13] == 3'b011 && prg[4];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string ptag;
    int win, ce, pb, cb;
    ptag = (ctrl[3:2] == 2'b11) ? "R1/R4" : (ctrl[3:2] == 2'b10) ? "R2/R4" : "R3/R4";
    pb = exp_prg_bank(); cb = exp_chr_bank();
    win = (cpu_valid && cpu_addr[15:13] == 3'b011) ? 1 : 0;
    ce  = (win == 1 && !prg[4]) ? 1 : 0;
    chk(ptag, int'(prg_addr), pb * 16384 + int'(cpu_addr[13:0]));
    chk(ctrl[4] ? "R5" : "R6", int'(chr_addr), cb * 4096 + int'(ppu_addr[11:0]));
    chk("R7", int'(mirror), int'(ctrl[1:0]));
    chk("R8 ce", int'(wram_ce), ce);
    chk("R8 we", int'(wram_we), (ce == 1 && cpu_we) ? 1 : 0);
    chk("R9 flag", int'(open_bus), int'(exp_open()));
    chk("R9 data", int'(open_bus_data), int'(exp_last));
    chk("R10", int'(wram_addr),
        int'(ctrl[4] ? chr0[4] : chr0[3]) * 8192 + int'(cpu_addr[12:0]));
    chk("R11 prg", int'(prg_addr_s), (pb % 8) * 16384 + int'(cpu_addr[13:0]));
    chk("R11 chr", int'(chr_addr_s), (cb % 8) * 4096 + int'(ppu_addr[11:0]));
    chk("R10 small", int'(wram_addr_s), int'(cpu_addr[12:0]));
  endtask

  task automatic step(input logic [4:0] c, c0, c1, p, input logic [15:0] a,
                      input logic v, w, input logic [7:0] d, input logic [12:0] pa);
    @(posedge clk);
    if (prev_cap) exp_last = prev_bus;
    #1;
    ctrl = c; chr0 = c0; chr1 = c1; prg = p; cpu_addr = a;
    cpu_valid = v; cpu_we = w; cpu_bus = d; ppu_addr = pa;
    #2;
    check_all();
    prev_cap = v && !exp_open();
    prev_bus = d;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #1;
    chk("R9 reset", int'(open_bus_data), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1/R4: fixed top bank of upper half = 31
    step(5'b01100, 5'b10000, 5'd0, 5'd3, 16'hC123, 1, 0, 8'h11, 13'h0);
    chk("R1 fixed", int'(prg_addr[18:14]), 31);
    // R2: fixed bank 0 of lower half
    step(5'b01000, 5'b00000, 5'd0, 5'd9, 16'h8004, 1, 0, 8'h22, 13'h0);
    chk("R2 fixed", int'(prg_addr[18:14]), 0);
    // R3: odd prg value 5 gives banks 4 and 5
    step(5'b00000, 5'b00000, 5'd0, 5'd5, 16'hC000, 1, 0, 8'h33, 13'h1000);
    chk("R3 high", int'(prg_addr[18:14]), 5);
    // R6: chr1 ignored in 8 KB mode
    step(5'b00000, 5'd7, 5'd30, 5'd0, 16'h0000, 0, 0, 8'h00, 13'h1ABC);
    chk("R6 chr1 ignored", int'(chr_addr[16:12]), 7);
    // R8/R9: write enabled RAM, then disabled reads return last value
    step(5'b00000, 5'd0, 5'd0, 5'd0, 16'h6010, 1, 1, 8'hA5, 13'h0);
    step(5'b00000, 5'd0, 5'd0, 5'h10, 16'h6010, 1, 0, 8'h5A, 13'h0);
    step(5'b00000, 5'd0, 5'd0, 5'h10, 16'h7FFF, 1, 0, 8'h77, 13'h0);
    chk("R9 held", int'(open_bus_data), 8'hA5);
    step(5'b00000, 5'd0, 5'd0, 5'h10, 16'h6000, 1, 1, 8'hEE, 13'h0);
    chk("R9 write dropped", int'(wram_we), 0);
    // R10: 16 KB work-RAM bank source per character mode
    step(5'b10000, 5'b10000, 5'd0, 5'd0, 16'h6000, 1, 0, 8'h01, 13'h0);
    chk("R10 4k", int'(wram_addr[13]), 1);
    step(5'b00000, 5'b01000, 5'd0, 5'd0, 16'h6000, 1, 0, 8'h02, 13'h0);
    chk("R10 8k", int'(wram_addr[13]), 1);
    // R12: change configuration with no clock edge
    step(5'b01100, 5'd0, 5'd0, 5'd2, 16'h8000, 0, 0, 8'h00, 13'h0);
    #1 prg = 5'd6; #1;
    chk("R12", int'(prg_addr[18:14]), 6);
    check_all();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(0, 2) == 0) a[15:13] = 3'b011;
      step(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), a,
           1'($urandom), 1'($urandom), 8'($urandom), 13'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule